// File: doc/BRIEF.md
# Flow-State Read/Write Buffer

This block sits between a packet pipeline and an external control RAM that holds one state record per flow. For every flow ID that enters on the request side, it issues a read to the control RAM and sends the returned state to the stage that loads the processor. When a processed packet comes back with modified state, the block takes that record and writes it back to the same RAM location.

Because packets of one flow follow each other closely, a later packet can ask for its state while the update from an earlier packet is still waiting to reach the RAM, or while a read for that flow is still in flight. The block holds pending write-backs in a small buffer. It searches that buffer by flow ID on every read, and it also watches updates that arrive while a read is outstanding. The record it delivers is therefore always the newest version of the flow's state. The RAM port carries one operation per cycle. The RAM can refuse a request through a ready signal, and it returns read data in request order after a variable delay of 5 to 10 cycles.

Top module: `flow_state_rwbuf`

## Requirements
- R1: While reset is held and right after it is released, `st_valid` and `ram_req_valid` are 0, `upd_ready` is 1, and `req_ready` equals `ram_req_ready`.
- R2: Every accepted update is written to the control RAM exactly once, in the order the updates were accepted, with address equal to the update's flow ID and data equal to its state. A write is issued only while an update is pending.
- R3: A read for a flow with no pending or in-flight update delivers the data that the RAM returned for that flow.
- R4: A read for a flow whose update is still held in the write buffer delivers the buffered record and not the stale RAM data. An update accepted in the same cycle as the read counts as buffered.
- R5: When several pending updates exist for the same flow, a read delivers the one accepted last.
- R6: An update for a flow that is accepted after that flow's read was issued, up to and including the cycle its RAM response arrives, replaces the returned RAM data.
- R7: The write buffer holds 8 records. `upd_ready` is 0 exactly when 8 updates are pending, and no update is accepted then.
- R8: Each RAM read response produces one output record one cycle later (`st_valid` high in the cycle after `ram_rsp_valid`, and low otherwise). Output records appear in request order, and `st_flow` carries the requested flow ID.
- R9: One RAM operation is issued per cycle, and only while `ram_req_ready` is 1. A read request is accepted whenever `ram_req_ready` is 1 and fewer than 16 reads are outstanding. In that cycle the read uses the port (`ram_req_we` = 0), and write-backs drain only in cycles without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Flow-ID request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_flow | input | 19 | Flow ID to fetch |
| upd_valid | input | 1 | Updated state present |
| upd_ready | output | 1 | Write buffer has room |
| upd_flow | input | 19 | Flow ID of the updated state |
| upd_state | input | 128 | Updated state record (4 words of 32 bits) |
| st_valid | output | 1 | Delivered state record valid |
| st_flow | output | 19 | Flow ID of the delivered record |
| st_state | output | 128 | Newest state of that flow |
| ram_req_valid | output | 1 | RAM operation issued |
| ram_req_ready | input | 1 | RAM accepts an operation this cycle |
| ram_req_we | output | 1 | 1 = write, 0 = read |
| ram_req_addr | output | 19 | RAM address (flow ID) |
| ram_req_wdata | output | 128 | Write data |
| ram_rsp_valid | input | 1 | Read data returning, in request order |
| ram_rsp_rdata | input | 128 | Read data |

## Verification
Fresh flows with nothing pending separate correct fetches from bypass errors, because the delivered data must match the RAM model. Holding the RAM off while updates pile up fills the buffer, which shows the stall point and, with repeated updates to one flow, whether the newest or an older copy wins the search. An update sent a few cycles after its flow's read shows whether in-flight data is patched. Random traffic over six flows, with random RAM latency and refusals, mixes all of these cases and compares every output and every RAM write against a per-flow shadow of the latest accepted state.

// File: rtl/fsrb_pkg.sv
package fsrb_pkg;
  localparam int FLOW_W      = 19;
  localparam int WORD_W      = 32;
  localparam int STATE_WORDS = 4;
  localparam int STATE_W     = WORD_W * STATE_WORDS;
  localparam int WBUF_DEPTH  = 8;
  localparam int PEND_DEPTH  = 16;
endpackage

// File: rtl/fsrb_wbuf.sv
// Write-back buffer: FIFO of pending updates, searchable by flow ID.
module fsrb_wbuf #(
  parameter int FW    = 19,
  parameter int DW    = 128,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [FW-1:0] push_flow,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [FW-1:0] look_flow,
  output logic          full,
  output logic          empty,
  output logic [FW-1:0] head_flow,
  output logic [DW-1:0] head_data,
  output logic          look_hit,
  output logic [DW-1:0] look_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [FW-1:0] e_flow [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [AW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    head_d = pop  ? head_q + 1'b1 : head_q;
    tail_d = push ? tail_q + 1'b1 : tail_q;
    cnt_d  = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      e_flow[tail_q] <= push_flow;
      e_data[tail_q] <= push_data;
    end
  end

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_flow = e_flow[head_q];
  assign head_data = e_data[head_q];

  // Walk from oldest to newest; the last match is the newest record.
  always_comb begin
    logic [AW-1:0] idx;
    look_hit  = 1'b0;
    look_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_q + AW'(k);
      if ((CW'(k) < cnt_q) && (e_flow[idx] == look_flow)) begin
        look_hit  = 1'b1;
        look_data = e_data[idx];
      end
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/fsrb_pend.sv
// Outstanding-read tracker: one entry per RAM read in flight, in order,
// each able to capture a newer record that supersedes the RAM data.
module fsrb_pend #(
  parameter int FW    = 19,
  parameter int DW    = 128,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [FW-1:0] push_flow,
  input  logic          push_ovr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          upd,
  input  logic [FW-1:0] upd_flow,
  input  logic [DW-1:0] upd_data,
  output logic          full,
  output logic          empty,
  output logic [FW-1:0] head_flow,
  output logic          head_ovr,
  output logic [DW-1:0] head_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [FW-1:0]    e_flow [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [DEPTH-1:0] e_ovr;
  logic [DEPTH-1:0] live;
  logic [AW-1:0]    head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  always_comb begin
    head_d = pop  ? head_q + 1'b1 : head_q;
    tail_d = push ? tail_q + 1'b1 : tail_q;
    cnt_d  = cnt_q + CW'(push) - CW'(pop);
  end

  always_comb begin
    logic [AW-1:0] age;
    for (int i = 0; i < DEPTH; i++) begin
      age     = AW'(i) - head_q;
      live[i] = (CW'(age) < cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (tail_q == AW'(i))) begin
        e_flow[i] <= push_flow;
        e_ovr[i]  <= push_ovr;
        e_data[i] <= push_data;
      end else if (upd && live[i] && (e_flow[i] == upd_flow)) begin
        e_ovr[i]  <= 1'b1;
        e_data[i] <= upd_data;
      end
    end
  end

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_flow = e_flow[head_q];
  assign head_ovr  = e_ovr[head_q];
  assign head_data = e_data[head_q];

  assert_rsp_has_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
endmodule

// File: rtl/flow_state_rwbuf.sv
module flow_state_rwbuf
  import fsrb_pkg::*;
#(
  parameter int FW         = FLOW_W,
  parameter int SW         = STATE_W,
  parameter int WB_DEPTH   = WBUF_DEPTH,
  parameter int RD_DEPTH   = PEND_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [FW-1:0] req_flow,
  input  logic          upd_valid,
  output logic          upd_ready,
  input  logic [FW-1:0] upd_flow,
  input  logic [SW-1:0] upd_state,
  output logic          st_valid,
  output logic [FW-1:0] st_flow,
  output logic [SW-1:0] st_state,
  output logic          ram_req_valid,
  input  logic          ram_req_ready,
  output logic          ram_req_we,
  output logic [FW-1:0] ram_req_addr,
  output logic [SW-1:0] ram_req_wdata,
  input  logic          ram_rsp_valid,
  input  logic [SW-1:0] ram_rsp_rdata
);
  logic          req_fire, upd_fire, drain;
  logic          wb_full, wb_empty, wb_hit;
  logic [FW-1:0] wb_head_flow;
  logic [SW-1:0] wb_head_data, wb_hit_data;
  logic          pd_full, pd_empty, pd_head_ovr;
  logic [FW-1:0] pd_head_flow;
  logic [SW-1:0] pd_head_data;
  logic          inc_hit, late_hit, issue_ovr;
  logic [SW-1:0] issue_data, rsp_data;

  logic          st_valid_q, st_valid_d;
  logic [FW-1:0] st_flow_q;
  logic [SW-1:0] st_state_q;

  // Port arbitration: an accepted read owns the port, writes fill gaps.
  assign req_ready = ram_req_ready && !pd_full;
  assign req_fire  = req_valid && req_ready;
  assign upd_ready = !wb_full;
  assign upd_fire  = upd_valid && upd_ready;
  assign drain     = ram_req_ready && !wb_empty && !req_fire;

  assign ram_req_valid = req_fire || drain;
  assign ram_req_we    = drain;
  assign ram_req_addr  = req_fire ? req_flow : wb_head_flow;
  assign ram_req_wdata = wb_head_data;

  // Bypass at issue: an update arriving now is newer than any buffered one.
  assign inc_hit    = upd_fire && (upd_flow == req_flow);
  assign issue_ovr  = inc_hit || wb_hit;
  assign issue_data = inc_hit ? upd_state : wb_hit_data;

  // Merge at response: an update arriving with the data is the newest.
  assign late_hit = upd_fire && (upd_flow == pd_head_flow);
  assign rsp_data = late_hit    ? upd_state    :
                    pd_head_ovr ? pd_head_data : ram_rsp_rdata;

  fsrb_wbuf #(.FW(FW), .DW(SW), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (upd_fire),
    .push_flow (upd_flow),
    .push_data (upd_state),
    .pop       (drain),
    .look_flow (req_flow),
    .full      (wb_full),
    .empty     (wb_empty),
    .head_flow (wb_head_flow),
    .head_data (wb_head_data),
    .look_hit  (wb_hit),
    .look_data (wb_hit_data)
  );

  fsrb_pend #(.FW(FW), .DW(SW), .DEPTH(RD_DEPTH)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_fire),
    .push_flow (req_flow),
    .push_ovr  (issue_ovr),
    .push_data (issue_data),
    .pop       (ram_rsp_valid),
    .upd       (upd_fire),
    .upd_flow  (upd_flow),
    .upd_data  (upd_state),
    .full      (pd_full),
    .empty     (pd_empty),
    .head_flow (pd_head_flow),
    .head_ovr  (pd_head_ovr),
    .head_data (pd_head_data)
  );

  assign st_valid_d = ram_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_valid_q <= 1'b0;
    else        st_valid_q <= st_valid_d;
  end

  always_ff @(posedge clk) begin
    if (ram_rsp_valid) begin
      st_flow_q  <= pd_head_flow;
      st_state_q <= rsp_data;
    end
  end

  assign st_valid = st_valid_q;
  assign st_flow  = st_flow_q;
  assign st_state = st_state_q;

  assert_read_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ram_req_ready && !pd_full) |-> (ram_req_valid && !ram_req_we));
  assert_port_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_req_ready |-> !ram_req_valid);
  assert_out_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rsp_valid |=> st_valid);
  assert_out_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_rsp_valid |=> !st_valid);
  assert_rsp_tracked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rsp_valid |-> !pd_empty);
  assert_stall_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_full |-> !upd_ready);
  assert_write_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req_valid && ram_req_we) |-> !wb_empty);
endmodule

// File: tb/flow_state_rwbuf_bench.sv
`timescale 1ns/1ps
module flow_state_rwbuf_bench;
  localparam int FW = 19;
  localparam int SW = 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready;
  logic [FW-1:0] req_flow;
  logic          upd_valid, upd_ready;
  logic [FW-1:0] upd_flow;
  logic [SW-1:0] upd_state;
  logic          st_valid;
  logic [FW-1:0] st_flow;
  logic [SW-1:0] st_state;
  logic          ram_req_valid, ram_req_ready, ram_req_we;
  logic [FW-1:0] ram_req_addr;
  logic [SW-1:0] ram_req_wdata;
  logic          ram_rsp_valid;
  logic [SW-1:0] ram_rsp_rdata;

  flow_state_rwbuf u_flow_state_rwbuf (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_flow(req_flow),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_flow(upd_flow),
    .upd_state(upd_state),
    .st_valid(st_valid), .st_flow(st_flow), .st_state(st_state),
    .ram_req_valid(ram_req_valid), .ram_req_ready(ram_req_ready),
    .ram_req_we(ram_req_we), .ram_req_addr(ram_req_addr),
    .ram_req_wdata(ram_req_wdata),
    .ram_rsp_valid(ram_rsp_valid), .ram_rsp_rdata(ram_rsp_rdata)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  int  cyc    = 0;
  int  last_due = 0;

  logic [SW-1:0] shadow [int];
  logic [SW-1:0] mem    [int];
  int            rq_due [$];
  logic [SW-1:0] rq_data[$];
  logic [FW-1:0] rd_flow[$];
  logic [FW-1:0] wq_flow[$];
  logic [SW-1:0] wq_data[$];

  bit            exp_pend = 1'b0;
  logic [FW-1:0] exp_flow;
  logic [SW-1:0] exp_data;
  string         data_tag = "R3";

  logic          d_req_valid = 1'b0, d_upd_valid = 1'b0, d_ram_ready = 1'b1;
  logic [FW-1:0] d_req_flow = '0, d_upd_flow = '0;
  logic [SW-1:0] d_upd_data = '0;
  bit            req_acc, upd_acc;

  logic [FW-1:0] pool [6] = '{19'h00000, 19'h7FFFF, 19'h12345,
                              19'h40001, 19'h2AAAA, 19'h05555};

  function automatic logic [SW-1:0] init_state(input logic [FW-1:0] f);
    return {{13'h1A5, f}, {13'h0, ~f}, 32'hC0DE0000 ^ {13'h0, f}, {f, 13'h7}};
  endfunction

  function automatic logic [SW-1:0] shadow_of(input logic [FW-1:0] f);
    return shadow.exists(int'(f)) ? shadow[int'(f)] : init_state(f);
  endfunction

  function automatic logic [SW-1:0] mem_of(input logic [FW-1:0] f);
    return mem.exists(int'(f)) ? mem[int'(f)] : init_state(f);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // One cycle, entered and left at a falling edge.
  task automatic step();
    bit rsp;
    int due;
    if (exp_pend) begin
      chk(st_valid === 1'b1, "R8", SW'(st_valid), 1);
      chk(st_flow === exp_flow, "R8", SW'(st_flow), SW'(exp_flow));
      chk(st_state === exp_data, data_tag, st_state, exp_data);
    end else begin
      chk(st_valid === 1'b0, "R8", SW'(st_valid), 0);
    end
    exp_pend = 1'b0;
    chk(upd_ready === (wq_flow.size() < 8), "R7", SW'(upd_ready),
        SW'(wq_flow.size() < 8));

    req_valid     = d_req_valid;
    req_flow      = d_req_flow;
    upd_valid     = d_upd_valid;
    upd_flow      = d_upd_flow;
    upd_state     = d_upd_data;
    ram_req_ready = d_ram_ready;
    rsp = 1'b0;
    if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
      rsp           = 1'b1;
      ram_rsp_valid = 1'b1;
      ram_rsp_rdata = rq_data.pop_front();
      void'(rq_due.pop_front());
    end else begin
      ram_rsp_valid = 1'b0;
      ram_rsp_rdata = '0;
    end
    #1;
    req_acc = req_valid && req_ready;
    upd_acc = upd_valid && upd_ready;

    chk(!(ram_req_valid && !d_ram_ready), "R9", SW'(ram_req_valid), 0);
    if (d_req_valid && d_ram_ready && rd_flow.size() < 16)
      chk(req_ready && ram_req_valid && !ram_req_we && ram_req_addr == d_req_flow,
          "R9", SW'({req_ready, ram_req_valid, ram_req_we}), SW'(3'b110));

    if (upd_acc) begin
      shadow[int'(d_upd_flow)] = d_upd_data;
      wq_flow.push_back(d_upd_flow);
      wq_data.push_back(d_upd_data);
    end
    if (ram_req_valid && d_ram_ready) begin
      if (ram_req_we) begin
        if (wq_flow.size() == 0) begin
          chk(1'b0, "R2", SW'(ram_req_addr), 0);
        end else begin
          chk(ram_req_addr == wq_flow[0] && ram_req_wdata == wq_data[0], "R2",
              ram_req_wdata, wq_data[0]);
          void'(wq_flow.pop_front());
          void'(wq_data.pop_front());
        end
        mem[int'(ram_req_addr)] = ram_req_wdata;
      end else begin
        due = cyc + 5 + int'($urandom % 6);
        if (rq_due.size() > 0 && due <= last_due) due = last_due + 1;
        last_due = due;
        rq_due.push_back(due);
        rq_data.push_back(mem_of(ram_req_addr));
        rd_flow.push_back(d_req_flow);
      end
    end
    if (rsp) begin
      if (rd_flow.size() == 0) begin
        chk(1'b0, "R8", 1, 0);
      end else begin
        exp_flow = rd_flow.pop_front();
        exp_data = shadow_of(exp_flow);
        exp_pend = 1'b1;
      end
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic quiet();
    d_req_valid = 1'b0;
    d_upd_valid = 1'b0;
    d_ram_ready = 1'b1;
    while (rd_flow.size() > 0 || exp_pend || wq_flow.size() > 0) step();
  endtask

  task automatic do_read(input logic [FW-1:0] f);
    d_req_valid = 1'b1;
    d_req_flow  = f;
    do step(); while (!req_acc);
    d_req_valid = 1'b0;
  endtask

  task automatic do_upd(input logic [FW-1:0] f, input logic [SW-1:0] v);
    d_upd_valid = 1'b1;
    d_upd_flow  = f;
    d_upd_data  = v;
    do step(); while (!upd_acc);
    d_upd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int acc;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    req_valid = 1'b0; req_flow = '0;
    upd_valid = 1'b0; upd_flow = '0; upd_state = '0;
    ram_req_ready = 1'b1; ram_rsp_valid = 1'b0; ram_rsp_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(st_valid === 1'b0 && ram_req_valid === 1'b0, "R1",
        SW'({st_valid, ram_req_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state after release
    chk(st_valid === 1'b0, "R1", SW'(st_valid), 0);
    chk(ram_req_valid === 1'b0, "R1", SW'(ram_req_valid), 0);
    chk(upd_ready === 1'b1, "R1", SW'(upd_ready), 1);
    chk(req_ready === 1'b1, "R1", SW'(req_ready), 1);
    ram_req_ready = 1'b0;
    #1;
    chk(req_ready === 1'b0, "R1", SW'(req_ready), 0);

    // R3: plain fetch of untouched flows
    data_tag = "R3";
    do_read(pool[0]);
    do_read(pool[2]);
    quiet();

    // R2: write-back reaches RAM, then fetch sees RAM copy
    do_upd(pool[1], 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    quiet();
    do_read(pool[1]);
    quiet();

    // R4: buffered update bypasses RAM
    data_tag = "R4";
    d_ram_ready = 1'b0;
    do_upd(pool[2], 128'hAAAA_0000_BBBB_0000_CCCC_0000_DDDD_0000);
    d_ram_ready = 1'b1;
    do_read(pool[2]);
    quiet();
    // R4: update and read for the same flow in one cycle
    d_upd_valid = 1'b1; d_upd_flow = pool[3];
    d_upd_data  = 128'h0F0F_0F0F_1234_5678_9ABC_DEF0_0000_0003;
    d_req_valid = 1'b1; d_req_flow = pool[3];
    step();
    chk(req_acc && upd_acc, "R4", SW'({req_acc, upd_acc}), 3);
    quiet();

    // R5: newest of several pending records
    data_tag = "R5";
    d_ram_ready = 1'b0;
    do_upd(pool[4], 128'h5);
    do_upd(pool[4], 128'h6);
    do_upd(pool[5], 128'h7);
    do_upd(pool[4], 128'h8);
    d_ram_ready = 1'b1;
    do_read(pool[4]);
    quiet();

    // R6: update lands while the read is in flight
    data_tag = "R6";
    do_read(pool[5]);
    step();
    do_upd(pool[5], 128'hFEED_FACE_0000_0001_0000_0002_0000_0003);
    quiet();

    // R7: buffer fills at 8 and stalls
    d_ram_ready = 1'b0;
    acc = 0;
    for (int i = 0; i < 11; i++) begin
      d_upd_valid = 1'b1;
      d_upd_flow  = pool[i % 6];
      d_upd_data  = {$urandom, $urandom, $urandom, $urandom};
      step();
      if (upd_acc) acc++;
    end
    chk(acc == 8, "R7", SW'(acc), 8);
    chk(upd_ready === 1'b0, "R7", SW'(upd_ready), 0);
    d_upd_valid = 1'b0;
    quiet();

    // Random traffic
    data_tag = "R3";
    for (int n = 0; n < 3000; n++) begin
      d_req_valid = ($urandom % 2) == 0;
      d_req_flow  = pool[$urandom % 6];
      d_upd_valid = ($urandom % 5) < 2;
      d_upd_flow  = pool[$urandom % 6];
      d_upd_data  = {$urandom, $urandom, $urandom, $urandom};
      d_ram_ready = ($urandom % 10) < 8;
      step();
    end
    quiet();
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule